// File: doc/BRIEF.md
# Four-Channel External Interrupt Trigger Unit

This block turns four asynchronous external interrupt inputs into sticky, software-visible interrupt requests. Each channel owns one mode bit and one polarity bit which together pick one of four trigger types: low level, high level, falling edge or rising edge. When a channel's trigger condition is seen, the channel's flag is set and held. The flag drives that channel's request line toward the CPU's interrupt controller until software clears it.

Each input passes through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one clock earlier. A channel can set its flag only while its pin-function input marks the pin as an external interrupt source. Software reads and writes the mode, polarity and flag registers through a plain single-cycle register port. Reads are combinational. Flags are cleared by writing ones.

The register port is plain control access, not a data stream. It has no handshake and no back-pressure: a write takes effect at the clock edge where `acc_wr` is high, and `acc_rdata` follows `acc_addr` within the same cycle.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, the mode, polarity and flag registers all read 0, `irq_req` is 0, and every channel is in low-level mode.
- R2: Register map on `acc_addr`: 0 = mode, 1 = polarity, 2 = flags, 3 = unused. Bit n of each register belongs to channel n. Only bits [3:0] are stored. Bits [31:4] and every bit at address 3 read as 0, and writes to address 3 change nothing.
- R3: Mode 0 with polarity 0 (low level): while the channel is enabled and its synchronised input is 0, the flag is set. An input that goes low before clock edge k sets the flag at edge k+2.
- R4: Mode 0 with polarity 1 (high level): while the channel is enabled and its synchronised input is 1, the flag is set, with the same latency as R3.
- R5: Mode 1 with polarity 0 (falling edge): a 1-to-0 change of the synchronised input sets the flag once. A held low level does not set it again after a clear.
- R6: Mode 1 with polarity 1 (rising edge): a 0-to-1 change of the synchronised input sets the flag once. A held high level does not set it again after a clear.
- R7: Writing to address 2 clears every flag whose write-data bit is 1 and leaves the flags whose write-data bit is 0 unchanged. A flag stays set until it is cleared this way.
- R8: In level mode, a clear has no lasting effect while the active level is still present at the synchronised input. Once the level has been gone for two edges, a clear succeeds.
- R9: A channel whose `pin_fn_irq` bit is 0 never sets its flag, whatever its input does.
- R10: If a trigger and a clearing write for the same channel occur at the same edge, the flag ends up set.
- R11: `irq_req[n]` equals flag bit n as read at address 2.
- R12: Channels are independent. Activity on one input, and clears aimed at other bits, leave a channel's flag untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 4 | Asynchronous external interrupt inputs, bit n for channel n |
| pin_fn_irq | input | 4 | Per-channel enable: 1 when the pin is set to the external-interrupt function |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | 2 | Register address (0 mode, 1 polarity, 2 flags, 3 unused) |
| acc_wdata | input | 32 | Register write data |
| acc_rdata | output | 32 | Register read data for `acc_addr` |
| irq_req | output | 4 | Per-channel interrupt request, equal to the flags |

## Verification
The hardest case to reach from the ports is a clearing write that lands on exactly the edge where a fresh trigger is evaluated. The input sits behind two synchroniser flops and an edge register, so the write has to be placed three cycles after the input change. The bench gets there in two ways. It times the clear against an edge-mode channel whose flag was already set by an earlier pulse. It also sweeps all 256 mode and polarity combinations while a pseudo-random input pattern and periodic partial clears run. A cycle-level model of the requirements predicts every flag and every read.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int unsigned ACC_ADDR_W = 2;

  typedef enum logic [ACC_ADDR_W-1:0] {
    ACC_MODE  = 2'd0,
    ACC_POL   = 2'd1,
    ACC_FLAG  = 2'd2,
    ACC_SPARE = 2'd3
  } acc_addr_e;

  typedef struct packed {
    logic edge_sel;
    logic active_high;
  } trig_cfg_t;

  // Trigger condition for one channel given its configuration
  function automatic logic trig_hit(trig_cfg_t cfg, logic cur, logic prev);
    logic hit;
    if (cfg.edge_sel) begin
      hit = cfg.active_high ? (cur & ~prev) : (~cur & prev);
    end else begin
      hit = cfg.active_high ? cur : ~cur;
    end
    return hit;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q[0] <= din;
      for (int k = 1; k < STAGES; k++) begin
        stage_q[k] <= stage_q[k-1];
      end
      prev_q <= stage_q[LAST];
    end
  end

  assign cur  = stage_q[LAST];
  assign prev = prev_q;

  // R5
  prev_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev == $past(cur)));

endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cur,
  input  logic [NUM_CH-1:0] prev,
  input  logic [NUM_CH-1:0] mode,
  input  logic [NUM_CH-1:0] pol,
  input  logic [NUM_CH-1:0] en,
  output logic [NUM_CH-1:0] trig
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    trig_cfg_t cfg;
    assign cfg.edge_sel    = mode[ch];
    assign cfg.active_high = pol[ch];

    always_comb begin
      trig[ch] = en[ch] & trig_hit(cfg, cur[ch], prev[ch]);
    end

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en[ch] |-> !trig[ch]);

    // R6
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[ch] && trig[ch]) |-> (cur[ch] != prev[ch]));
  end

endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_wr,
  input  logic [ACC_ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0]     acc_wdata,
  output logic [DATA_W-1:0]     acc_rdata,
  input  logic [NUM_CH-1:0]     trig,
  output logic [NUM_CH-1:0]     mode,
  output logic [NUM_CH-1:0]     pol,
  output logic [NUM_CH-1:0]     flag
);

  acc_addr_e        sel;
  logic [NUM_CH-1:0] clr;
  logic              unused_wdata_hi;

  assign sel             = acc_addr_e'(acc_addr);
  assign unused_wdata_hi = ^acc_wdata[DATA_W-1:NUM_CH];

  always_comb begin
    clr = '0;
    if (acc_wr && sel == ACC_FLAG) begin
      clr = acc_wdata[NUM_CH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      pol  <= '0;
      flag <= '0;
    end else begin
      if (acc_wr && sel == ACC_MODE) mode <= acc_wdata[NUM_CH-1:0];
      if (acc_wr && sel == ACC_POL)  pol  <= acc_wdata[NUM_CH-1:0];
      flag <= (flag & ~clr) | trig;
    end
  end

  always_comb begin
    unique case (sel)
      ACC_MODE: acc_rdata = DATA_W'(mode);
      ACC_POL:  acc_rdata = DATA_W'(pol);
      ACC_FLAG: acc_rdata = DATA_W'(flag);
      default:  acc_rdata = '0;
    endcase
  end

  // R2
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rdata[DATA_W-1:NUM_CH] == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R7
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[ch] && !trig[ch]) |=> !flag[ch]);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[ch] && !clr[ch]) |=> flag[ch]);

    // R10
    trigger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig[ch] |=> flag[ch]);

    // R12
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[ch] && !trig[ch]) |=> !flag[ch]);
  end

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     ext_pin,
  input  logic [NUM_CH-1:0]     pin_fn_irq,
  input  logic                  acc_wr,
  input  logic [ACC_ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0]     acc_wdata,
  output logic [DATA_W-1:0]     acc_rdata,
  output logic [NUM_CH-1:0]     irq_req
);

  logic [NUM_CH-1:0] cur;
  logic [NUM_CH-1:0] prev;
  logic [NUM_CH-1:0] mode;
  logic [NUM_CH-1:0] pol;
  logic [NUM_CH-1:0] flag;
  logic [NUM_CH-1:0] trig;

  extint_sync #(
    .WIDTH  (NUM_CH),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ext_pin),
    .cur   (cur),
    .prev  (prev)
  );

  extint_detect #(
    .NUM_CH (NUM_CH)
  ) i_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .cur   (cur),
    .prev  (prev),
    .mode  (mode),
    .pol   (pol),
    .en    (pin_fn_irq),
    .trig  (trig)
  );

  extint_regs #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .trig      (trig),
    .mode      (mode),
    .pol       (pol),
    .flag      (flag)
  );

  assign irq_req = flag;

  // R11
  req_matches_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == ACC_FLAG) |-> (acc_rdata[NUM_CH-1:0] == irq_req));

endmodule

// File: tb/test_extint_ctrl.sv
module test_extint_ctrl;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ext_pin;
  logic [3:0]  pin_fn_irq;
  logic        acc_wr;
  logic [1:0]  acc_addr;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic [3:0]  irq_req;

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  // Requirement-level model state
  logic [3:0] m_s1, m_s2, m_p, m_mode, m_pol, m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  extint_ctrl i_extint_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_pin    (ext_pin),
    .pin_fn_irq (pin_fn_irq),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .irq_req    (irq_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input logic [3:0] diff);
    string t = "R12";
    for (int ch = 3; ch >= 0; ch--) begin
      if (diff[ch]) begin
        if (!m_mode[ch]) t = m_pol[ch] ? "R4" : "R3";
        else             t = m_pol[ch] ? "R6" : "R5";
      end
    end
    return t;
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return {28'd0, m_mode};
      2'd1:    return {28'd0, m_pol};
      2'd2:    return {28'd0, m_flag};
      default: return 32'd0;
    endcase
  endfunction

  // Called at a falling edge; drives one cycle, checks, advances model
  task automatic step(input string tag, input logic [3:0] ext, input logic [3:0] en,
                      input logic wr, input logic [1:0] addr, input logic [31:0] wd);
    logic [3:0] trig, clr;
    ext_pin = ext; pin_fn_irq = en; acc_wr = wr; acc_addr = addr; acc_wdata = wd;
    #1;
    chk(tag == "" ? tag_for(irq_req ^ m_flag) : tag, {28'd0, irq_req}, {28'd0, m_flag});
    chk(addr == 2'd2 ? "R11" : "R2", acc_rdata, model_read(addr));
    for (int ch = 0; ch < 4; ch++) begin
      if (m_mode[ch]) trig[ch] = m_pol[ch] ? (m_s2[ch] & ~m_p[ch]) : (~m_s2[ch] & m_p[ch]);
      else            trig[ch] = (m_s2[ch] == m_pol[ch]);
      trig[ch] = trig[ch] & en[ch];
    end
    clr = (wr && addr == 2'd2) ? wd[3:0] : 4'd0;
    m_flag = (m_flag & ~clr) | trig;
    m_p  = m_s2;
    m_s2 = m_s1;
    m_s1 = ext;
    if (wr && addr == 2'd0) m_mode = wd[3:0];
    if (wr && addr == 2'd1) m_pol  = wd[3:0];
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input logic [3:0] ext, input logic [3:0] en, input int n);
    for (int i = 0; i < n; i++) step(tag, ext, en, 1'b0, 2'd3, 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    rst_n = 1'b0; ext_pin = 4'h0; pin_fn_irq = 4'h0;
    acc_wr = 1'b0; acc_addr = 2'd0; acc_wdata = 32'd0;
    {m_s1, m_s2, m_p, m_mode, m_pol, m_flag} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      acc_addr = 2'(a); #1;
      chk("R1", acc_rdata, 32'd0);
    end
    chk("R1", {28'd0, irq_req}, 32'd0);
    // R1: low-level mode by default, enabling with input low sets the flags
    idle("R1", 4'h0, 4'h0, 3);
    idle("R1", 4'h0, 4'hF, 1);
    chk("R1", {28'd0, irq_req}, 32'hF);
    step("R7", 4'hF, 4'h0, 1'b1, 2'd2, 32'hFFFF_FFFF);
    chk("R7", {28'd0, irq_req}, 32'h0);

    // R2: register map, upper bits, spare address
    step("R2", 4'hF, 4'h0, 1'b1, 2'd0, 32'hFFFF_FFFA);
    step("R2", 4'hF, 4'h0, 1'b1, 2'd1, 32'h1234_5675);
    step("R2", 4'hF, 4'h0, 1'b1, 2'd3, 32'hFFFF_FFFF);
    acc_addr = 2'd0; #1; chk("R2", acc_rdata, 32'hA);
    acc_addr = 2'd1; #1; chk("R2", acc_rdata, 32'h5);
    acc_addr = 2'd3; #1; chk("R2", acc_rdata, 32'h0);

    // R9: disabled channel ignores a held active level
    step("R9", 4'hF, 4'h0, 1'b1, 2'd0, 32'h0);
    step("R9", 4'hF, 4'h0, 1'b1, 2'd1, 32'h0);
    idle("R9", 4'h0, 4'h0, 6);
    chk("R9", {28'd0, irq_req}, 32'h0);
    idle("R9", 4'h0, 4'h1, 1);
    chk("R9", {28'd0, irq_req}, 32'h1);
    idle("R9", 4'hF, 4'h0, 3);
    step("R7", 4'hF, 4'h0, 1'b1, 2'd2, 32'h0);
    chk("R7", {28'd0, irq_req}, 32'h1);
    step("R7", 4'hF, 4'h0, 1'b1, 2'd2, 32'h1);
    chk("R7", {28'd0, irq_req}, 32'h0);

    // R8: high-level channel 1, clear while level present has no lasting effect
    step("R8", 4'h0, 4'h0, 1'b1, 2'd1, 32'h2);
    idle("R8", 4'h2, 4'h2, 4);
    chk("R8", {28'd0, irq_req}, 32'h2);
    step("R8", 4'h2, 4'h2, 1'b1, 2'd2, 32'h2);
    chk("R8", {28'd0, irq_req}, 32'h2);
    idle("R8", 4'h0, 4'h2, 2);
    step("R8", 4'h0, 4'h2, 1'b1, 2'd2, 32'h2);
    chk("R8", {28'd0, irq_req}, 32'h0);

    // R10: rising edge channel 3, clear lands on the retrigger edge
    step("R10", 4'h0, 4'h0, 1'b1, 2'd0, 32'h8);
    step("R10", 4'h0, 4'h0, 1'b1, 2'd1, 32'h8);
    idle("R10", 4'h0, 4'h8, 3);
    idle("R10", 4'h8, 4'h8, 3);
    chk("R6", {28'd0, irq_req}, 32'h8);
    idle("R10", 4'h0, 4'h8, 3);
    step("R10", 4'h8, 4'h8, 1'b0, 2'd3, 32'h0);
    step("R10", 4'h8, 4'h8, 1'b0, 2'd3, 32'h0);
    step("R10", 4'h8, 4'h8, 1'b1, 2'd2, 32'h8);
    chk("R10", {28'd0, irq_req}, 32'h8);
    step("R6", 4'h8, 4'h8, 1'b1, 2'd2, 32'h8);
    idle("R6", 4'h8, 4'h8, 3);
    chk("R6", {28'd0, irq_req}, 32'h0);

    // R12: all rising, only channel 2 toggles
    step("R12", 4'h0, 4'h0, 1'b1, 2'd0, 32'hF);
    step("R12", 4'h0, 4'h0, 1'b1, 2'd1, 32'hF);
    idle("R12", 4'h0, 4'hF, 3);
    idle("R12", 4'h4, 4'hF, 3);
    chk("R12", {28'd0, irq_req}, 32'h4);
    step("R12", 4'h4, 4'hF, 1'b1, 2'd2, 32'hB);
    chk("R12", {28'd0, irq_req}, 32'h4);

    // Sweep all mode/polarity combinations with pseudo-random stimulus
    lfsr = 8'h5A;
    for (int cfg = 0; cfg < 256; cfg++) begin
      step("", lfsr[3:0], 4'hF, 1'b1, 2'd0, 32'(cfg[3:0]));
      step("", lfsr[3:0], 4'hF, 1'b1, 2'd1, 32'(cfg[7:4]));
      for (int c = 0; c < 30; c++) begin
        logic [3:0] en;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        en = (c >= 12 && c < 18) ? (4'(cfg) ^ 4'(cfg >> 4)) : 4'hF;
        if (c % 3 == 2)
          step("", lfsr[3:0], en, 1'b1, 2'd2, {28'hFFFF_FFF, lfsr[7:4] | 4'(c)});
        else
          step("", (c % 2 == 0) ? lfsr[3:0] : ext_pin, en, 1'b0, 2'(c), 32'd0);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule